// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block lives inside an SDRAM controller and is the only agent that issues refresh-related commands. A free-running interval timer adds one unit of refresh debt per interval. Whenever debt is outstanding the block asks the controller's arbiter for the command bus. Once granted, it waits until every open bank has been active long enough. It then closes all banks with a single precharge-all, lets the precharge time run out, issues one auto-refresh and fills the recovery time with NOPs. Finally it hands the bus back with a one-cycle completion pulse.

The same bus ownership is used for low-power entry. When the low-power request is raised, the next grant leads (after closing banks if needed) into self-refresh with the clock enable driven low. Dropping the request brings the clock enable back high and holds NOPs for the recovery time before the bus is returned. The arbiter sees a plain level request, an urgency flag for refresh debt that has hit its ceiling, and a completion pulse. The bank state comes in as per-bank open flags and per-bank row-active ages in clock cycles, maintained by the controller.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Out of reset the pins carry a NOP (CS#=0, RAS#=1, CAS#=1, WE#=1) with CKE=1 and A10=0, and `ref_req`, `ref_done`, `ref_urgent` and `lp_ack` are all 0.
- R2: The refresh interval is REF_CYC = CLK_MHZ*REF_INTERVAL_NS/1000 cycles. With no grant, `ref_req` is 0 through the first REF_CYC-1 rising edges after reset release and is 1 after edge REF_CYC.
- R3: Debt grows by one per interval and saturates at DEBT_MAX. `ref_urgent` is 1 exactly while debt equals DEBT_MAX. Each auto-refresh lowers debt by one, so after saturation exactly DEBT_MAX granted refreshes are served before `ref_req` falls.
- R4: `ref_req` is 1 only in the idle state, when debt is nonzero or `lp_req` is 1. `ref_gnt` is sampled only on an edge where `ref_req` is 1; otherwise it has no effect on the pins.
- R5: If no bank is open when the grant is sampled, auto-refresh (CS#=0, RAS#=0, CAS#=0, WE#=1, CKE=1) appears in the cycle right after that edge.
- R6: Precharge-all (CS#=0, RAS#=0, CAS#=1, WE#=0, A10=1) is issued only when every bank with its `bank_open` bit set has `bank_age` of at least TRAS_CYC. While any open bank is younger, NOPs are driven, and an age of TRAS_CYC-1 is not enough.
- R7: Auto-refresh (or self-refresh entry) follows precharge-all exactly TRP_CYC cycles later, with NOPs in between.
- R8: The recovery time is TRFC_CYC = ceil(TRFC_NS*CLK_MHZ/1000) cycles (66 ns at 200 MHz gives 14). The TRFC_CYC-1 cycles after an auto-refresh are NOPs, and `ref_done` is a single-cycle pulse TRFC_CYC cycles after the auto-refresh.
- R9: When the grant is sampled with `lp_req` at 1, the block enters self-refresh with CS#=0, RAS#=0, CAS#=0, WE#=1 and CKE=0. `lp_ack` rises in that same cycle and is 0 during any preceding precharge.
- R10: In self-refresh CKE stays 0 and CS# stays 1 for as long as `lp_req` stays 1. `ref_req` stays 0 there, and grants and interval expiries have no effect.
- R11: On the edge after `lp_req` falls in self-refresh, CKE returns to 1 with a NOP. NOPs with `lp_ack`=1 last TRFC_CYC cycles, then `ref_done` pulses with `lp_ack` at 0.
- R12: Self-refresh discards all refresh debt and restarts the interval timer. After the exit completion pulse, `ref_req` stays 0 for REF_CYC-1 edges and rises on edge REF_CYC.
- R13: Auto-refresh is only issued with no bank open and with CKE high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | output | 1 | Bus request to the arbiter (refresh debt or low-power request) |
| ref_gnt | input | 1 | Arbiter grant, sampled while `ref_req` is high |
| ref_done | output | 1 | One-cycle pulse: bus returned to the arbiter |
| ref_urgent | output | 1 | Refresh debt has reached DEBT_MAX |
| bank_open | input | NBANK | Per-bank row-open flags |
| bank_age | input | NBANK*AGE_W | Per-bank cycles since activation, bank i at bits [i*AGE_W +: AGE_W] |
| lp_req | input | 1 | Low-power (self-refresh) request, level |
| lp_ack | output | 1 | High from self-refresh entry until the exit recovery ends |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_a10 | output | 1 | SDRAM A10, high selects all banks for precharge |

## Verification
Every pin is a decode of the state register. A command caused by a grant sampled at rising edge k is therefore visible in the cycle after edge k. From there, precharge-all is followed by auto-refresh TRP_CYC edges later, the completion pulse is TRFC_CYC edges after the auto-refresh, and CKE returns one edge after `lp_req` falls. Debt effects show up on `ref_req` one edge after the interval counter reaches its last value. The bench drives inputs at falling edges and counts rising edges from a known point: a reset release, a grant, or a completion pulse. It samples at the falling edge where each of these results is due, and also checks every intermediate cycle of the NOP windows.

// File: rtl/sdr_ref_pkg.sv
`timescale 1ns/1ps
package sdr_ref_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TRAS,
    ST_PREA,
    ST_RP,
    ST_AREF,
    ST_RFC,
    ST_SRE,
    ST_SRH,
    ST_SRX,
    ST_DONE
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
`timescale 1ns/1ps
module ref_interval_timer #(
  parameter int REF_CYC  = 3120,
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  output logic debt_nz,
  output logic debt_full
);

  localparam int CNT_W  = (REF_CYC > 2) ? $clog2(REF_CYC) : 1;
  localparam int DEBT_W = $clog2(DEBT_MAX + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(REF_CYC - 1);
  localparam logic [DEBT_W-1:0] DEBT_TOP = DEBT_W'(DEBT_MAX);

  logic [CNT_W-1:0]  cnt;
  logic [DEBT_W-1:0] debt;
  logic              tick;

  assign tick = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      debt <= '0;
    end else if (clr) begin
      cnt  <= '0;
      debt <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      unique case ({tick, take})
        2'b10:   if (debt != DEBT_TOP) debt <= debt + 1'b1;
        2'b01:   if (debt != '0)       debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  assign debt_nz   = (debt != '0);
  assign debt_full = (debt == DEBT_TOP);

endmodule

// File: rtl/seq_wait_counter.sv
`timescale 1ns/1ps
module seq_wait_counter #(
  parameter int MAXV = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [$clog2(MAXV+1)-1:0]   load_val,
  output logic                        zero
);

  localparam int W = $clog2(MAXV + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/bank_tras_gate.sv
`timescale 1ns/1ps
module bank_tras_gate #(
  parameter int NBANK    = 4,
  parameter int AGE_W    = 8,
  parameter int TRAS_CYC = 9
) (
  input  logic [NBANK-1:0]       bank_open,
  input  logic [NBANK*AGE_W-1:0] bank_age,
  output logic                   any_open,
  output logic                   all_ready
);

  localparam logic [AGE_W-1:0] AGE_MIN = AGE_W'(TRAS_CYC);

  logic [NBANK-1:0] ok;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign ok[i] = !bank_open[i] || (bank_age[i*AGE_W +: AGE_W] >= AGE_MIN);
  end

  assign any_open  = |bank_open;
  assign all_ready = &ok;

endmodule

// File: rtl/sdram_refresh_seq.sv
`timescale 1ns/1ps
module sdram_refresh_seq
  import sdr_ref_pkg::*;
#(
  parameter int NBANK           = 4,
  parameter int AGE_W           = 8,
  parameter int CLK_MHZ         = 200,
  parameter int REF_INTERVAL_NS = 15600,
  parameter int DEBT_MAX        = 8,
  parameter int TRAS_CYC        = 9,
  parameter int TRP_CYC         = 4,
  parameter int TRFC_NS         = 66
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   ref_req,
  input  logic                   ref_gnt,
  output logic                   ref_done,
  output logic                   ref_urgent,
  input  logic [NBANK-1:0]       bank_open,
  input  logic [NBANK*AGE_W-1:0] bank_age,
  input  logic                   lp_req,
  output logic                   lp_ack,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic                   sd_cke,
  output logic                   sd_a10
);

  localparam int REF_CYC  = (CLK_MHZ * REF_INTERVAL_NS) / 1000;
  localparam int TRFC_CYC = ceil_div(TRFC_NS * CLK_MHZ, 1000);
  localparam int WMAX     = (TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC;
  localparam int WW       = $clog2(WMAX + 1);
  localparam logic [WW-1:0] LD_RP  = WW'((TRP_CYC  >= 2) ? TRP_CYC  - 2 : 0);
  localparam logic [WW-1:0] LD_RFC = WW'((TRFC_CYC >= 2) ? TRFC_CYC - 2 : 0);
  localparam logic [WW-1:0] LD_SRX = WW'((TRFC_CYC >= 1) ? TRFC_CYC - 1 : 0);

  seq_state_t st, st_n;
  logic       goal_sr, goal_n;
  logic       debt_nz, debt_full;
  logic       any_open, all_ready;
  logic       wait_zero, wait_load;
  logic [WW-1:0] wait_val;
  logic       in_sr;
  sdr_cmd_t   cmd;

  assign in_sr = (st == ST_SRE) || (st == ST_SRH) || (st == ST_SRX);

  ref_interval_timer #(
    .REF_CYC (REF_CYC),
    .DEBT_MAX(DEBT_MAX)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (in_sr),
    .take     (st == ST_AREF),
    .debt_nz  (debt_nz),
    .debt_full(debt_full)
  );

  bank_tras_gate #(
    .NBANK   (NBANK),
    .AGE_W   (AGE_W),
    .TRAS_CYC(TRAS_CYC)
  ) u_gate (
    .bank_open(bank_open),
    .bank_age (bank_age),
    .any_open (any_open),
    .all_ready(all_ready)
  );

  // Wait counter is loaded on the edge that leaves a command state.
  always_comb begin
    wait_load = 1'b0;
    wait_val  = '0;
    unique case (st)
      ST_PREA: begin wait_load = 1'b1; wait_val = LD_RP;  end
      ST_AREF: begin wait_load = 1'b1; wait_val = LD_RFC; end
      ST_SRH:  begin wait_load = !lp_req; wait_val = LD_SRX; end
      default: begin wait_load = 1'b0; wait_val = '0; end
    endcase
  end

  seq_wait_counter #(
    .MAXV(WMAX)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wait_load),
    .load_val(wait_val),
    .zero    (wait_zero)
  );

  assign ref_req = (st == ST_IDLE) && (debt_nz || lp_req);

  always_comb begin
    st_n   = st;
    goal_n = goal_sr;
    unique case (st)
      ST_IDLE: begin
        if (ref_req && ref_gnt) begin
          goal_n = lp_req;
          if (!any_open)      st_n = lp_req ? ST_SRE : ST_AREF;
          else if (all_ready) st_n = ST_PREA;
          else                st_n = ST_TRAS;
        end
      end
      ST_TRAS: begin
        if (!any_open)      st_n = goal_sr ? ST_SRE : ST_AREF;
        else if (all_ready) st_n = ST_PREA;
      end
      ST_PREA: st_n = ST_RP;
      ST_RP:   if (wait_zero) st_n = goal_sr ? ST_SRE : ST_AREF;
      ST_AREF: st_n = ST_RFC;
      ST_RFC:  if (wait_zero) st_n = ST_DONE;
      ST_SRE:  st_n = ST_SRH;
      ST_SRH:  if (!lp_req) st_n = ST_SRX;
      ST_SRX:  if (wait_zero) st_n = ST_DONE;
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      goal_sr <= 1'b0;
    end else begin
      st      <= st_n;
      goal_sr <= goal_n;
    end
  end

  // Pin decode straight from the state register.
  always_comb begin
    unique case (st)
      ST_PREA: cmd = CMD_PRE;
      ST_AREF: cmd = CMD_REF;
      ST_SRE:  cmd = CMD_REF;
      ST_SRH:  cmd = CMD_DESEL;
      default: cmd = CMD_NOP;
    endcase
  end

  assign sd_cs_n    = cmd.cs_n;
  assign sd_ras_n   = cmd.ras_n;
  assign sd_cas_n   = cmd.cas_n;
  assign sd_we_n    = cmd.we_n;
  assign sd_a10     = (st == ST_PREA);
  assign sd_cke     = !((st == ST_SRE) || (st == ST_SRH));
  assign lp_ack     = in_sr;
  assign ref_done   = (st == ST_DONE);
  assign ref_urgent = debt_full;

endmodule

// File: rtl/ref_seq_checker.sv
`timescale 1ns/1ps
module ref_seq_checker #(
  parameter int NBANK    = 4,
  parameter int AGE_W    = 8,
  parameter int CLK_MHZ  = 200,
  parameter int TRAS_CYC = 9,
  parameter int TRFC_NS  = 66
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ref_req,
  input logic                   ref_done,
  input logic [NBANK-1:0]       bank_open,
  input logic [NBANK*AGE_W-1:0] bank_age,
  input logic                   lp_ack,
  input logic                   sd_cs_n,
  input logic                   sd_ras_n,
  input logic                   sd_cas_n,
  input logic                   sd_we_n,
  input logic                   sd_cke,
  input logic                   sd_a10
);

  localparam int TRFC_CYC = (TRFC_NS * CLK_MHZ + 999) / 1000;
  localparam int CW = $clog2(TRFC_CYC + 1);

  logic [3:0] pins;
  logic is_nop, is_aref, is_prea;
  logic [NBANK-1:0] aged;
  logic [CW-1:0] win;

  assign pins    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_aref = (pins == 4'b0001) && sd_cke;
  assign is_prea = (pins == 4'b0010) && sd_a10;

  for (genvar i = 0; i < NBANK; i++) begin : g_age
    assign aged[i] = !bank_open[i] || (int'(bank_age[i*AGE_W +: AGE_W]) >= TRAS_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win <= '0;
    else if (is_aref)    win <= CW'(TRFC_CYC - 1);
    else if (win != '0)  win <= win - 1'b1;
  end

  a_r13_aref_legal: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |-> (bank_open == '0) && $past(sd_cke));

  a_r6_prea_tras: assert property (@(posedge clk) disable iff (!rst_n)
    is_prea |-> (&aged));

  a_r8_rfc_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> is_nop && sd_cke);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  a_r9_ack_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> lp_ack);

  a_r4_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !lp_ack && !ref_done);

  a_r10_sr_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cke && $past(!sd_cke)) |-> sd_cs_n);

  a_r11_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> is_nop && lp_ack);

endmodule

bind sdram_refresh_seq ref_seq_checker #(
  .NBANK   (NBANK),
  .AGE_W   (AGE_W),
  .CLK_MHZ (CLK_MHZ),
  .TRAS_CYC(TRAS_CYC),
  .TRFC_NS (TRFC_NS)
) u_ref_seq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_req  (ref_req),
  .ref_done (ref_done),
  .bank_open(bank_open),
  .bank_age (bank_age),
  .lp_ack   (lp_ack),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_cke   (sd_cke),
  .sd_a10   (sd_a10)
);

// File: tb/tb_sdram_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdram_refresh_seq;

  localparam int NB  = 4;
  localparam int AW  = 8;
  localparam int R_E    = 200;  // 200 MHz * 1000 ns
  localparam int TRFC_E = 14;   // ceil(66 ns * 200 MHz)
  localparam int TRP_E  = 4;
  localparam int TRAS_E = 8;
  localparam int DMAX   = 8;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic lp_req = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [NB*AW-1:0] bank_age = '0;
  logic ref_req, ref_done, ref_urgent, lp_ack;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_a10;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(
    .NBANK(NB), .AGE_W(AW), .CLK_MHZ(200), .REF_INTERVAL_NS(1000),
    .DEBT_MAX(DMAX), .TRAS_CYC(TRAS_E), .TRP_CYC(TRP_E), .TRFC_NS(66)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ref_done(ref_done), .ref_urgent(ref_urgent), .bank_open(bank_open),
    .bank_age(bank_age), .lp_req(lp_req), .lp_ack(lp_ack),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_a10(sd_a10)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_pins(input string tag, input logic [3:0] exp, input logic ecke);
    logic [4:0] act;
    act = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke};
    chk(act == {exp, ecke}, tag, int'(act), int'({exp, ecke}));
  endtask

  // Grant is already sampled; we are in the auto-refresh cycle.
  task automatic aref_tail(input string tag);
    chk_pins({tag, " R5 aref pins"}, P_REF, 1'b1);
    ref_gnt = 1'b0;
    for (int i = 1; i < TRFC_E; i++) begin
      tick(1);
      chk_pins({tag, " R8 rfc nop"}, P_NOP, 1'b1);
      chk(ref_done == 1'b0, {tag, " R8 no early done"}, ref_done, 0);
    end
    tick(1);
    chk(ref_done == 1'b1, {tag, " R8 done at trfc"}, ref_done, 1);
    tick(1);
    chk(ref_done == 1'b0, {tag, " R8 done one cycle"}, ref_done, 0);
  endtask

  task automatic sr_exit(input string tag);
    lp_req = 1'b0;
    tick(1);
    chk_pins({tag, " R11 cke up nop"}, P_NOP, 1'b1);
    chk(lp_ack == 1'b1, {tag, " R11 ack held"}, lp_ack, 1);
    for (int i = 1; i < TRFC_E; i++) begin
      tick(1);
      chk_pins({tag, " R11 exit nop"}, P_NOP, 1'b1);
      chk(lp_ack == 1'b1 && ref_done == 1'b0, {tag, " R11 ack window"}, lp_ack, 1);
    end
    tick(1);
    chk(ref_done == 1'b1 && lp_ack == 1'b0, {tag, " R11 done ack low"},
        int'({ref_done, lp_ack}), 2);
  endtask

  task automatic t_reset();
    tick(2);
    chk_pins("R1 reset pins", P_NOP, 1'b1);
    chk(sd_a10 == 1'b0, "R1 a10", sd_a10, 0);
    chk({ref_req, ref_done, ref_urgent, lp_ack} == 4'b0, "R1 outputs",
        int'({ref_req, ref_done, ref_urgent, lp_ack}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_interval();
    tick(R_E - 1);
    chk(ref_req == 1'b0, "R2 no req before interval", ref_req, 0);
    tick(1);
    chk(ref_req == 1'b1, "R2 req after interval", ref_req, 1);
  endtask

  // Self-refresh entered while one refresh is owed.
  task automatic t_selfref();
    lp_req = 1'b1;
    ref_gnt = 1'b1;
    tick(1);
    chk_pins("R9 sr entry pins", P_REF, 1'b0);
    chk(lp_ack == 1'b1, "R9 ack with cke low", lp_ack, 1);
    ref_gnt = 1'b0;
    for (int i = 0; i < R_E + 20; i++) begin
      ref_gnt = i[2];
      tick(1);
      chk(sd_cke == 1'b0 && sd_cs_n == 1'b1 && ref_req == 1'b0 && lp_ack == 1'b1,
          "R10 sr hold", int'({sd_cke, sd_cs_n, ref_req, lp_ack}), 5);
    end
    ref_gnt = 1'b0;
    sr_exit("sr1");
    // R12: debt discarded, timer restarted; R4: stray grants ignored
    for (int i = 1; i < R_E; i++) begin
      ref_gnt = (i > 10 && i < 30);
      tick(1);
      chk(ref_req == 1'b0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP,
          "R12 R4 no req after exit", ref_req, 0);
    end
    ref_gnt = 1'b0;
    tick(1);
    chk(ref_req == 1'b1, "R12 req one interval after exit", ref_req, 1);
  endtask

  task automatic t_debt();
    int served;
    tick(7 * R_E - 1);
    chk(ref_urgent == 1'b0, "R3 urgent below limit", ref_urgent, 0);
    tick(1);
    chk(ref_urgent == 1'b1, "R3 urgent at limit", ref_urgent, 1);
    tick(2 * R_E);
    chk(ref_urgent == 1'b1, "R3 urgent saturated", ref_urgent, 1);
    served = 0;
    while (ref_req && served < 20) begin
      ref_gnt = 1'b1;
      tick(1);
      aref_tail("debt");
      served++;
      if (served == 1)
        chk(ref_urgent == 1'b0, "R3 urgent clears after one", ref_urgent, 0);
    end
    chk(served == DMAX, "R3 refreshes served", served, DMAX);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 3 * R_E && !ref_req; i++) tick(1);
  endtask

  task automatic t_tras();
    wait_req();
    chk(ref_req == 1'b1, "R4 req for tras test", ref_req, 1);
    bank_open = 4'b0010;
    bank_age  = '0;
    bank_age[1*AW +: AW] = 8'd3;
    ref_gnt = 1'b1;
    tick(1);
    ref_gnt = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk_pins("R6 wait young bank", P_NOP, 1'b1);
      tick(1);
    end
    bank_age[1*AW +: AW] = 8'(TRAS_E - 1);
    tick(1);
    chk_pins("R6 age tras-1 still waits", P_NOP, 1'b1);
    bank_age[1*AW +: AW] = 8'(TRAS_E);
    tick(1);
    chk_pins("R6 prea pins", P_PRE, 1'b1);
    chk(sd_a10 == 1'b1, "R6 a10 high", sd_a10, 1);
    bank_open = '0;
    for (int i = 1; i < TRP_E; i++) begin
      tick(1);
      chk_pins("R7 rp nop", P_NOP, 1'b1);
    end
    tick(1);
    aref_tail("tras");
  endtask

  task automatic t_sr_open();
    bank_open = 4'b0001;
    bank_age[0 +: AW] = 8'd20;
    lp_req = 1'b1;
    tick(1);
    ref_gnt = 1'b1;
    tick(1);
    ref_gnt = 1'b0;
    chk_pins("R6 prea before sr", P_PRE, 1'b1);
    chk(lp_ack == 1'b0, "R9 no ack during prea", lp_ack, 0);
    bank_open = '0;
    tick(TRP_E - 1);
    chk_pins("R7 rp nop before sr", P_NOP, 1'b1);
    tick(1);
    chk_pins("R7 R9 sr entry after trp", P_REF, 1'b0);
    tick(5);
    sr_exit("sr2");
  endtask

  initial begin
    t_reset();
    t_interval();
    t_selfref();
    t_debt();
    t_tras();
    t_sr_open();
    tick(3);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule